// File: doc/BRIEF.md
# Integer Execute Stage with Host Mailbox

This block is the second stage of a two-stage integer pipeline. Every clock it takes one already-decoded operation, reads up to two source registers from a 32-entry register file, and forms a result. The result can come from an adder/subtractor, a bitwise logic unit, a barrel shifter, a signed or unsigned less-than compare, an upper-immediate former, the data-memory read bus, a link value supplied by fetch, or a small coprocessor. The block writes that result back in the same cycle. Loads and stores go out as single-cycle data-memory accesses. The address, write-data and read-data buses are separate and one-directional, and a single write strobe marks a store.

The coprocessor holds two 8-bit host registers. The first is an outbound register that drives the `tohost` pins and is written by a coprocessor move into index 21. The test environment watches this register, and any non-zero value on it means the running program has finished. The second is an inbound register, read at index 20, that returns the `fromhost` pins zero-extended to 32 bits. Integer arithmetic never traps: sums and differences wrap.

Top module: `exu_top`

## Requirements
- R1: Register 0 always reads as zero. A write-back addressed to register 0 has no effect.
- R2: alu_op 0 (add) and 1 (subtract, rs minus B) produce the low 32 bits of the result and wrap silently on overflow.
- R3: alu_op 2/3/4/5 give AND/OR/XOR/NOR of rs and B. With imm_sext=0 the 16-bit immediate is zero-extended to form B.
- R4: alu_op 6 compares rs<B as signed and alu_op 7 compares it as unsigned. The result is written as 0 or 1. With imm_sext=1 the immediate is sign-extended before the compare.
- R5: alu_op 8/9/10 shift rt left, right with zero fill, and right with sign fill. The amount comes from the shamt port when shift_by_reg=0, and from rs[4:0] when shift_by_reg=1.
- R6: alu_op 11 writes the 16-bit immediate into bits [31:16] and zeros into bits [15:0].
- R7: The data address is rs plus the sign-extended immediate, with bits [1:0] forced to zero. dmem_wdata carries rt. dmem_we equals mem_store. wb_sel 1 writes dmem_rdata to the destination register.
- R8: wb_sel 2 writes link_pc to the destination register.
- R9: tohost resets to zero. It loads rt[7:0] in the cycle after cop_write is asserted with cop_reg=21. A write to any other coprocessor index leaves tohost unchanged.
- R10: wb_sel 3 with cop_reg=20 writes fromhost zero-extended to 32 bits.
- R11: A register write completes at the clock edge that ends its cycle. A read of the same register in that cycle returns the old value, and the next cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_op | input | 4 | Result function: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 slt, 7 sltu, 8 sll, 9 srl, 10 sra, 11 upper-immediate |
| rs_idx | input | 5 | First source register index |
| rt_idx | input | 5 | Second source register index |
| rd_idx | input | 5 | Destination register index |
| rf_we | input | 1 | Register write enable |
| imm | input | 16 | Immediate field |
| imm_sext | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| use_imm | input | 1 | 1 selects the immediate as operand B, 0 selects rt |
| shamt | input | 5 | Constant shift amount |
| shift_by_reg | input | 1 | 1 takes the shift amount from rs[4:0] |
| wb_sel | input | 2 | Write-back source: 0 ALU, 1 memory, 2 link, 3 coprocessor |
| link_pc | input | 32 | Return address supplied by fetch |
| mem_store | input | 1 | Store request |
| cop_write | input | 1 | Coprocessor register write |
| cop_reg | input | 5 | Coprocessor register index |
| fromhost | input | 8 | Inbound host value |
| dmem_rdata | input | 32 | Data read back from memory |
| tohost | output | 8 | Outbound host register |
| dmem_addr | output | 32 | Word-aligned data address |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 32 | Store data |

## Verification
A register-file read and a write-back to the same register can fall in the same cycle, as with an accumulate of the form r5 = r5 + r1. The bench provokes this by issuing that accumulate three times back to back. It then reads the register out through a store and expects the initial value plus three times the increment. Any forwarding of the new value, or any loss of a write, changes that sum.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int XLEN  = 32;
    localparam int IMM_W = 16;

    typedef enum logic [3:0] {
        FN_ADD  = 4'd0,
        FN_SUB  = 4'd1,
        FN_AND  = 4'd2,
        FN_OR   = 4'd3,
        FN_XOR  = 4'd4,
        FN_NOR  = 4'd5,
        FN_SLT  = 4'd6,
        FN_SLTU = 4'd7,
        FN_SLL  = 4'd8,
        FN_SRL  = 4'd9,
        FN_SRA  = 4'd10,
        FN_LUI  = 4'd11
    } fn_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2,
        WB_COP  = 2'd3
    } wb_e;

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] v, input logic sgn);
        return sgn ? {{(XLEN-IMM_W){v[IMM_W-1]}}, v} : {{(XLEN-IMM_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/exu_regfile.sv
module exu_regfile #(
    parameter int W    = exu_pkg::XLEN,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // R11
    rf_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

    // R1
    rf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_a == '0) |-> (rd_a == '0));
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int W     = XLEN,
    localparam int SH_W = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst,
    input  fn_e             fn,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    y
);
    logic          is_sub;
    logic [W-1:0]  sum;

    assign is_sub = (fn == FN_SUB);
    assign sum    = a + (is_sub ? ~b : b) + {{(W-1){1'b0}}, is_sub};

    always_comb begin
        unique case (fn)
            FN_ADD, FN_SUB: y = sum;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_NOR:  y = ~(a | b);
            FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            FN_SLTU: y = {{(W-1){1'b0}}, (a < b)};
            FN_SLL:  y = b << amt;
            FN_SRL:  y = b >> amt;
            FN_SRA:  y = W'($signed(b) >>> amt);
            FN_LUI:  y = {b[IMM_W-1:0], {(W-IMM_W){1'b0}}};
            default: y = '0;
        endcase
    end

    // R4
    slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_SLT || fn == FN_SLTU) |-> (y[W-1:1] == '0));
endmodule

// File: rtl/exu_hostregs.sv
module exu_hostregs #(
    parameter int W        = exu_pkg::XLEN,
    parameter int HOST_W   = 8,
    parameter int COP_AW   = 5,
    parameter int TO_IDX   = 21,
    parameter int FROM_IDX = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [COP_AW-1:0] idx,
    input  logic [HOST_W-1:0] wdata,
    input  logic [HOST_W-1:0] from_pins,
    output logic [HOST_W-1:0] to_q,
    output logic [W-1:0]      rdata
);
    logic hit_to;
    assign hit_to = (idx == COP_AW'(TO_IDX));

    always_ff @(posedge clk) begin
        if (rst)              to_q <= '0;
        else if (wr && hit_to) to_q <= wdata;
    end

    always_comb begin
        if (idx == COP_AW'(FROM_IDX)) rdata = W'(from_pins);
        else if (hit_to)              rdata = W'(to_q);
        else                          rdata = '0;
    end

    // R9
    tohost_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == COP_AW'(TO_IDX)) |=> (to_q == $past(wdata)));

    // R9
    tohost_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && idx == COP_AW'(TO_IDX)) |=> $stable(to_q));
endmodule

// File: rtl/exu_top.sv
module exu_top
    import exu_pkg::*;
#(
    parameter int DATA_W       = XLEN,
    parameter int NREG         = 32,
    parameter int HOST_W       = 8,
    parameter int COP_AW       = 5,
    parameter int TOHOST_REG   = 21,
    parameter int FROMHOST_REG = 20,
    localparam int AW          = $clog2(NREG),
    localparam int SH_W        = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        alu_op,
    input  logic [AW-1:0]     rs_idx,
    input  logic [AW-1:0]     rt_idx,
    input  logic [AW-1:0]     rd_idx,
    input  logic              rf_we,
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_sext,
    input  logic              use_imm,
    input  logic [SH_W-1:0]   shamt,
    input  logic              shift_by_reg,
    input  logic [1:0]        wb_sel,
    input  logic [DATA_W-1:0] link_pc,
    input  logic              mem_store,
    input  logic              cop_write,
    input  logic [COP_AW-1:0] cop_reg,
    input  logic [HOST_W-1:0] fromhost,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic [HOST_W-1:0] tohost,
    output logic [DATA_W-1:0] dmem_addr,
    output logic              dmem_we,
    output logic [DATA_W-1:0] dmem_wdata
);
    logic [DATA_W-1:0] rs_val, rt_val, op_b, alu_y, cop_y, wb_val;
    logic [SH_W-1:0]   amt;
    wb_e               wb_src;

    assign op_b   = use_imm ? widen_imm(imm, imm_sext) : rt_val;
    assign amt    = shift_by_reg ? rs_val[SH_W-1:0] : shamt;
    assign wb_src = wb_e'(wb_sel);

    exu_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .ra_a(rs_idx), .ra_b(rt_idx),
        .rd_a(rs_val), .rd_b(rt_val),
        .we(rf_we), .wa(rd_idx), .wd(wb_val)
    );

    exu_alu #(.W(DATA_W)) u_alu (
        .clk(clk), .rst(rst),
        .fn(fn_e'(alu_op)), .a(rs_val), .b(op_b), .amt(amt), .y(alu_y)
    );

    exu_hostregs #(
        .W(DATA_W), .HOST_W(HOST_W), .COP_AW(COP_AW),
        .TO_IDX(TOHOST_REG), .FROM_IDX(FROMHOST_REG)
    ) u_host (
        .clk(clk), .rst(rst),
        .wr(cop_write), .idx(cop_reg), .wdata(rt_val[HOST_W-1:0]),
        .from_pins(fromhost), .to_q(tohost), .rdata(cop_y)
    );

    always_comb begin
        unique case (wb_src)
            WB_ALU:  wb_val = alu_y;
            WB_MEM:  wb_val = dmem_rdata;
            WB_LINK: wb_val = link_pc;
            WB_COP:  wb_val = cop_y;
            default: wb_val = alu_y;
        endcase
    end

    assign dmem_addr  = {alu_y[DATA_W-1:2], 2'b00};
    assign dmem_we    = mem_store;
    assign dmem_wdata = rt_val;
endmodule

// File: tb/exu_top_bench.sv
module exu_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  alu_op;
    logic [4:0]  rs_idx, rt_idx, rd_idx, shamt, cop_reg;
    logic        rf_we, imm_sext, use_imm, shift_by_reg, mem_store, cop_write;
    logic [15:0] imm;
    logic [1:0]  wb_sel;
    logic [31:0] link_pc, dmem_rdata, dmem_addr, dmem_wdata;
    logic [7:0]  fromhost, tohost;
    logic        dmem_we;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    localparam logic [3:0] ADD = 0, SUB = 1, AND_ = 2, OR_ = 3, XOR_ = 4, NOR_ = 5,
                           SLT = 6, SLTU = 7, SLL = 8, SRL = 9, SRA = 10, LUI = 11;

    always #5 clk = ~clk;

    exu_top u_exu_top (
        .clk(clk), .rst(rst), .alu_op(alu_op), .rs_idx(rs_idx), .rt_idx(rt_idx),
        .rd_idx(rd_idx), .rf_we(rf_we), .imm(imm), .imm_sext(imm_sext),
        .use_imm(use_imm), .shamt(shamt), .shift_by_reg(shift_by_reg),
        .wb_sel(wb_sel), .link_pc(link_pc), .mem_store(mem_store),
        .cop_write(cop_write), .cop_reg(cop_reg), .fromhost(fromhost),
        .dmem_rdata(dmem_rdata), .tohost(tohost), .dmem_addr(dmem_addr),
        .dmem_we(dmem_we), .dmem_wdata(dmem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_op = ADD; rs_idx = 0; rt_idx = 0; rd_idx = 0; rf_we = 0; imm = 0;
        imm_sext = 0; use_imm = 0; shamt = 0; shift_by_reg = 0; wb_sel = 0;
        link_pc = 0; mem_store = 0; cop_write = 0; cop_reg = 0; dmem_rdata = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic op_rr(input logic [3:0] f, input int d, input int s, input int t);
        idle(); alu_op = f; rs_idx = 5'(s); rt_idx = 5'(t); rd_idx = 5'(d); rf_we = 1;
        step();
    endtask

    task automatic op_ri(input logic [3:0] f, input int d, input int s,
                         input logic [15:0] v, input logic sx);
        idle(); alu_op = f; rs_idx = 5'(s); rd_idx = 5'(d); rf_we = 1;
        use_imm = 1; imm = v; imm_sext = sx;
        step();
    endtask

    task automatic op_sh(input logic [3:0] f, input int d, input int t, input int amt_reg,
                         input logic [4:0] n);
        idle(); alu_op = f; rt_idx = 5'(t); rd_idx = 5'(d); rf_we = 1; shamt = n;
        rs_idx = 5'(amt_reg); shift_by_reg = (amt_reg != 0);
        step();
    endtask

    task automatic set_reg(input int r, input logic [31:0] v);
        op_ri(LUI, r, 0, v[31:16], 1'b0);
        op_ri(OR_, r, r, v[15:0], 1'b0);
    endtask

    // store of register r at address 0, used to bring register contents out
    task automatic read_reg(input int r, output logic [31:0] v);
        idle(); rt_idx = 5'(r); mem_store = 1; use_imm = 1; imm_sext = 1;
        #1 v = dmem_wdata;
        step();
    endtask

    task automatic expect_reg(input string req, input int r, input logic [31:0] e);
        logic [31:0] v;
        read_reg(r, v);
        chk(req, v, e);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R9 tohost after reset", 32'(tohost), 32'h0);
        idle(); #1;
        chk("R7 no store strobe when idle", 32'(dmem_we), 32'h0);
        step();
        read_reg(7, v);
        chk("R1 reset register contents", v, 32'h0);
    endtask

    task automatic t_zero();
        op_ri(ADD, 0, 0, 16'h0005, 1'b1);
        expect_reg("R1 register 0 ignores writes", 0, 32'h0);
    endtask

    task automatic t_arith();
        set_reg(1, 32'hFFFF_FFFF); set_reg(2, 32'h2);
        op_rr(ADD, 3, 1, 2);
        expect_reg("R2 add wraps", 3, 32'h1);
        op_rr(SUB, 4, 0, 2);
        expect_reg("R2 subtract wraps below zero", 4, 32'hFFFF_FFFE);
        set_reg(5, 32'h7FFF_FFFF);
        op_ri(ADD, 6, 5, 16'h0001, 1'b1);
        expect_reg("R2 signed overflow wraps", 6, 32'h8000_0000);
    endtask

    task automatic t_logic();
        logic [31:0] a = 32'hF0F0_1234, b = 32'h0FF0_FF00;
        set_reg(1, a); set_reg(2, b);
        op_rr(AND_, 3, 1, 2); expect_reg("R3 and", 3, a & b);
        op_rr(OR_,  3, 1, 2); expect_reg("R3 or",  3, a | b);
        op_rr(XOR_, 3, 1, 2); expect_reg("R3 xor", 3, a ^ b);
        op_rr(NOR_, 3, 1, 2); expect_reg("R3 nor", 3, ~(a | b));
        op_ri(OR_, 4, 0, 16'h8001, 1'b0);
        expect_reg("R3 immediate zero-extended", 4, 32'h0000_8001);
    endtask

    task automatic t_cmp();
        set_reg(1, 32'hFFFF_FFFB); set_reg(2, 32'h3);
        op_rr(SLT, 3, 1, 2);  expect_reg("R4 signed less", 3, 32'h1);
        op_rr(SLTU, 3, 1, 2); expect_reg("R4 unsigned not less", 3, 32'h0);
        op_ri(SLT, 4, 2, 16'hFFFF, 1'b1);
        expect_reg("R4 signed immediate -1", 4, 32'h0);
        op_ri(SLTU, 4, 2, 16'hFFFF, 1'b1);
        expect_reg("R4 unsigned immediate max", 4, 32'h1);
    endtask

    task automatic t_shift();
        logic [31:0] v = 32'h8000_00F0;
        set_reg(1, v); set_reg(2, 32'd36);
        op_sh(SLL, 3, 1, 0, 5'd4); expect_reg("R5 left shift", 3, v << 4);
        op_sh(SRL, 3, 1, 0, 5'd4); expect_reg("R5 logical right zero fill", 3, 32'h0800_000F);
        op_sh(SRA, 3, 1, 0, 5'd4); expect_reg("R5 arithmetic right sign fill", 3, 32'hF800_000F);
        op_sh(SRA, 3, 1, 2, 5'd0); expect_reg("R5 amount from rs low bits", 3, 32'hF800_000F);
        op_sh(SRL, 3, 1, 0, 5'd31); expect_reg("R5 max amount", 3, 32'h1);
    endtask

    task automatic t_lui();
        op_ri(LUI, 5, 0, 16'hABCD, 1'b1);
        expect_reg("R6 upper immediate", 5, 32'hABCD_0000);
    endtask

    task automatic t_mem();
        set_reg(1, 32'h0000_1003); set_reg(2, 32'h1234_5678);
        idle(); alu_op = ADD; rs_idx = 1; rt_idx = 2; use_imm = 1; imm = 16'hFFFC;
        imm_sext = 1; mem_store = 1;
        #1;
        chk("R7 store address aligned", dmem_addr, 32'h0000_0FFC);
        chk("R7 store strobe", 32'(dmem_we), 32'h1);
        chk("R7 store data", dmem_wdata, 32'h1234_5678);
        step();
        idle(); alu_op = ADD; rs_idx = 1; rd_idx = 6; rf_we = 1; use_imm = 1;
        imm = 16'h0004; imm_sext = 1; wb_sel = 2'd1; dmem_rdata = 32'hDEAD_BEEF;
        #1;
        chk("R7 load address", dmem_addr, 32'h0000_1004);
        chk("R7 no strobe on load", 32'(dmem_we), 32'h0);
        step();
        expect_reg("R7 load write-back", 6, 32'hDEAD_BEEF);
    endtask

    task automatic t_link();
        idle(); rd_idx = 31; rf_we = 1; wb_sel = 2'd2; link_pc = 32'h0000_1008;
        step();
        expect_reg("R8 link value", 31, 32'h0000_1008);
    endtask

    task automatic t_host();
        set_reg(7, 32'h0000_01A5);
        idle(); cop_write = 1; cop_reg = 21; rt_idx = 7;
        #1 chk("R9 tohost before edge", 32'(tohost), 32'h0);
        step();
        chk("R9 tohost written", 32'(tohost), 32'hA5);
        set_reg(8, 32'h0000_0011);
        idle(); cop_write = 1; cop_reg = 22; rt_idx = 8;
        step();
        chk("R9 other index ignored", 32'(tohost), 32'hA5);
        fromhost = 8'h9C;
        idle(); cop_reg = 20; rd_idx = 9; rf_we = 1; wb_sel = 2'd3;
        step();
        expect_reg("R10 fromhost zero-extended", 9, 32'h0000_009C);
    endtask

    task automatic t_same_cycle();
        set_reg(5, 32'd10); set_reg(1, 32'd3);
        for (int i = 0; i < 3; i++) op_rr(ADD, 5, 5, 1);
        expect_reg("R11 read old value while writing", 5, 32'd19);
    endtask

    task automatic t_reset_again();
        rst = 1; step(); rst = 0;
        chk("R9 tohost cleared by reset", 32'(tohost), 32'h0);
    endtask

    initial begin
        idle(); fromhost = 0; rst = 1;
        @(negedge clk); step(); rst = 0;
        t_reset();
        t_zero();
        t_arith();
        t_logic();
        t_cmp();
        t_shift();
        t_lui();
        t_mem();
        t_link();
        t_host();
        t_same_cycle();
        t_reset_again();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule